// File: doc/BRIEF.md
# MDIO Management Command Port

This block gives software a single 32-bit command register for talking to an external Ethernet PHY over a two-wire management link (MDC clock, MDIO data). One write to the command register packs the PHY address, the PHY register number, a read/write selector and, for writes, 16 bits of data. The block serializes that command as a Clause 22 management frame and shows its progress through status bits in the same register. A busy flag covers the whole frame. After a read, the returned 16 bits appear in the low half of the register, and a read-valid flag stays up until software reads the command register.

A second register holds a 5-bit default PHY address. Software may use it to remember where the PHY was found. Writes change only its low five bits.

MDC is produced from the system clock by a parameterized divider. MDIO has a separate output-enable, so the pad can be released while the PHY drives the read turnaround and the data bits.

Top module: `mgmt_cmd_port`

## Requirements
- R1: After reset the command register reads 0 (not busy, read-valid clear), MDC is low, the MDIO output-enable is low, and the PHY-address register reads 0.
- R2: A write to the command register (regSel=0) while idle starts a frame, and busy (bit 28) reads 1 in the cycle after the write. The word carries the PHY address in bits 20:16, the register number in bits 25:21 and the opcode in bit 26 (1 = read, 0 = write). These fields read back in the same positions.
- R3: A write frame drives, MSB first and with output-enable high throughout: 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10, then the 16 data bits taken from command bits 15:0.
- R4: A read frame drives 32 ones, 01, opcode 10, PHY address and register number (46 bits). It then releases MDIO (output-enable low) for the two turnaround bits and the 16 data bits.
- R5: On a read, MDIO is sampled on the rising MDC edges of the 16 data bits, MSB first. When the frame ends, the value appears in bits 15:0 and read-valid (bit 27) is set.
- R6: Read-valid stays set across any number of cycles and is cleared by a read strobe on the command register. Bits 15:0 keep their value.
- R7: MDC is low while idle and has a period of 2*CLK_DIV system clocks during a frame. A frame lasts 64 MDC periods, so busy clears 128*CLK_DIV cycles after the accepting edge.
- R8: A command write while busy is ignored. The frame on the wire and the stored fields stay those of the first command.
- R9: A write to the PHY-address register (regSel=1) stores only data bits 4:0. Reading it returns those bits with bits 31:5 zero.
- R10: A command write with any of bits 31:27 set is rejected. No frame starts, busy stays 0 and the stored fields keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (clears read-valid on the command register) |
| regSel | input | 1 | 0 = command register, 1 = PHY-address register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Management data driven toward the PHY |
| mdioOe | output | 1 | Output-enable for the MDIO pad |
| mdioIn | input | 1 | Management data from the PHY |

## Verification
Frames are launched with random addresses, register numbers, data words and PHY responses. These are mixed with directed extremes: all-zero and all-one fields, address 0 against register 31 and the reverse, and a read response with only the end bits set. That combination shows whether field packing, MSB-first ordering and sampling alignment are right. Write frames are compared bit by bit across all 64 positions. Read frames are compared over the driven 46 bits, and the enable pattern separates a correct release point from an early or late one. A mid-frame second command, a command with reserved bits set and repeated reads of a valid result separate real ignoring and holding from incidental behaviour.

// File: rtl/mgmt_pkg.sv
`timescale 1ns/1ps
package mgmt_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2*ADDR_W + 2 + DATA_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_POS     = FRAME_BITS - DATA_W - 2;
  localparam int DATA_POS   = FRAME_BITS - DATA_W;
  localparam int PHY_LSB    = 16;
  localparam int REG_LSB    = 21;
  localparam int OP_BIT     = 26;
  localparam int RV_BIT     = 27;
  localparam int BUSY_BIT   = 28;

  typedef struct packed {
    logic load;
    logic shiftNext;
    logic sampleIn;
    logic done;
  } mgmtStrobe_t;
endpackage

// File: rtl/mgmt_ctrl.sv
`timescale 1ns/1ps
module mgmt_ctrl
  import mgmt_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output mgmtStrobe_t      stb,
  output logic             busy,
  output logic             mdc,
  output logic [IDX_W-1:0] bitIdx
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0] divCnt;
  logic tick;

  assign tick = busy && (divCnt == DIV_LAST);

  always_comb begin
    stb.load      = !busy && start;
    stb.sampleIn  = tick && !mdc;
    stb.shiftNext = tick && mdc && (bitIdx != LAST_BIT);
    stb.done      = tick && mdc && (bitIdx == LAST_BIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (!busy) begin
      busy   <= start;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (tick) begin
      divCnt <= '0;
      mdc    <= ~mdc;
      if (mdc) begin
        if (bitIdx == LAST_BIT) busy <= 1'b0;
        else bitIdx <= bitIdx + 1'b1;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_datapath.sv
`timescale 1ns/1ps
module mgmt_datapath
  import mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mgmtStrobe_t       stb,
  input  logic              busy,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [OP_BIT:0]   cmdIn,
  input  logic              rdClr,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              isRead,
  output logic [ADDR_W-1:0] phyField,
  output logic [ADDR_W-1:0] regField,
  output logic [DATA_W-1:0] dataReg,
  output logic              rdValid
);
  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] frameInit;
  logic [DATA_W-1:0]     capShift;
  logic                  newRead;
  logic                  inRelease;
  logic                  inData;

  assign newRead = cmdIn[OP_BIT];

  always_comb begin
    frameInit = {{PRE_BITS{1'b1}}, 2'b01,
                 newRead ? 2'b10 : 2'b01,
                 cmdIn[PHY_LSB +: ADDR_W],
                 cmdIn[REG_LSB +: ADDR_W],
                 newRead ? 2'b00 : 2'b10,
                 newRead ? {DATA_W{1'b0}} : cmdIn[DATA_W-1:0]};
  end

  assign inRelease = isRead && (bitIdx >= IDX_W'(TA_POS));
  assign inData    = isRead && (bitIdx >= IDX_W'(DATA_POS));
  assign mdioOe    = busy && !inRelease;
  assign mdioOut   = mdioOe && shiftReg[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      capShift <= '0;
      isRead   <= 1'b0;
      phyField <= '0;
      regField <= '0;
      dataReg  <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (rdClr) rdValid <= 1'b0;
      if (stb.load) begin
        shiftReg <= frameInit;
        isRead   <= newRead;
        phyField <= cmdIn[PHY_LSB +: ADDR_W];
        regField <= cmdIn[REG_LSB +: ADDR_W];
        dataReg  <= cmdIn[DATA_W-1:0];
        rdValid  <= 1'b0;
      end
      if (stb.shiftNext) shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
      if (stb.sampleIn && inData) capShift <= {capShift[DATA_W-2:0], mdioIn};
      if (stb.done && isRead) begin
        dataReg <= capShift;
        rdValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mgmt_cmd_port.sv
`timescale 1ns/1ps
module mgmt_cmd_port
  import mgmt_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        regSel,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mgmtStrobe_t       stb;
  logic              busy;
  logic [IDX_W-1:0]  bitIdx;
  logic              isRead;
  logic [ADDR_W-1:0] phyField;
  logic [ADDR_W-1:0] regField;
  logic [DATA_W-1:0] dataReg;
  logic              rdValid;
  logic [ADDR_W-1:0] phyAddrQ;
  logic              start;
  logic              rdClr;

  assign start = wrEn && !regSel && (wrData[31:RV_BIT] == '0);
  assign rdClr = rdEn && !regSel;

  mgmt_ctrl #(.CLK_DIV(CLK_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .stb(stb),
    .busy(busy), .mdc(mdc), .bitIdx(bitIdx)
  );

  mgmt_datapath uData (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .bitIdx(bitIdx),
    .cmdIn(wrData[OP_BIT:0]), .rdClr(rdClr), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .isRead(isRead),
    .phyField(phyField), .regField(regField), .dataReg(dataReg),
    .rdValid(rdValid)
  );

  always_ff @(posedge clk) begin
    if (!rstN) phyAddrQ <= '0;
    else if (wrEn && regSel) phyAddrQ <= wrData[ADDR_W-1:0];
  end

  always_comb begin
    if (regSel) rdData = {{(32-ADDR_W){1'b0}}, phyAddrQ};
    else rdData = {3'b000, busy, rdValid, isRead, regField, phyField, dataReg};
  end
endmodule

// File: rtl/mgmt_cmd_port_chk.sv
`timescale 1ns/1ps
module mgmt_cmd_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        rdEn,
  input logic        regSel,
  input logic [31:0] wrData,
  input logic        busy,
  input logic        rdValid,
  input logic        mdc,
  input logic        mdioOe,
  input logic        isRead,
  input logic [4:0]  regField,
  input logic [4:0]  phyField
);
  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !regSel && !busy && (wrData[31:27] == 5'd0)) |=> busy); // R2

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe)); // R7

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && !regSel) |=> $stable({isRead, regField, phyField})); // R8

  AST_RV_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdEn && !regSel) |=> !rdValid); // R6

  AST_RV_SET: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && isRead) |-> rdValid); // R5

  AST_RESERVED_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !regSel && !busy && (wrData[31:27] != 5'd0)) |=> !busy); // R10
endmodule

bind mgmt_cmd_port mgmt_cmd_port_chk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
  .wrData(wrData), .busy(busy), .rdValid(rdValid), .mdc(mdc),
  .mdioOe(mdioOe), .isRead(isRead), .regField(regField), .phyField(phyField)
);

// File: tb/sim_mgmt_cmd_port.sv
`timescale 1ns/1ps
module sim_mgmt_cmd_port;
  localparam int CLK_DIV = 2;
  localparam logic [63:0] RD_OE_MASK = 64'hFFFF_FFFF_FFFC_0000;

  logic clk = 1'b0;
  logic rstN, wrEn, rdEn, regSel, mdioIn;
  logic [31:0] wrData, rdData;
  logic mdc, mdioOut, mdioOe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [63:0] capBits, capOe;
  int riseCnt, fallCnt;
  bit capOn = 0;
  bit phyResp = 0;
  logic [15:0] respWord;

  always #2.5 clk = ~clk;

  mgmt_cmd_port #(.CLK_DIV(CLK_DIV)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // PHY model: record what is on the wire at each rising MDC edge
  always @(posedge mdc) begin
    if (capOn && riseCnt < 64) begin
      capBits[63-riseCnt] = mdioOut;
      capOe[63-riseCnt]   = mdioOe;
    end
    riseCnt++;
  end

  // PHY model: present read data after the falling edge that opens each data bit
  always @(negedge mdc) begin
    fallCnt++;
    if (capOn && phyResp && fallCnt >= 48 && fallCnt <= 63)
      mdioIn = respWord[15-(fallCnt-48)];
    else
      mdioIn = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(input bit rd, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    return {5'b00000, rd, rg, phy, d};
  endfunction

  function automatic logic [63:0] expFrame(input bit rd, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, rd ? 2'b00 : 2'b10, rd ? 16'h0000 : d};
  endfunction

  // all tasks are entered at a falling clock edge
  task automatic busWrite(input bit sel, input logic [31:0] d);
    wrEn = 1'b1; regSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 32'h0;
  endtask

  task automatic busRead(input bit sel, output logic [31:0] v);
    rdEn = 1'b1; regSel = sel;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peek(input bit sel, output logic [31:0] v);
    regSel = sel;
    #1 v = rdData;
  endtask

  task automatic runTxn(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] d, input logic [15:0] resp, input bit intrude);
    logic [31:0] v, v2;
    logic [63:0] exp;
    int n;
    riseCnt = 0; fallCnt = 0; capBits = '0; capOe = '0;
    capOn = 1; phyResp = rd; respWord = resp;
    exp = expFrame(rd, phy, rg, d);
    busWrite(1'b0, mkCmd(rd, phy, rg, d));
    peek(1'b0, v);
    check(v[28] == 1'b1, "R2 busy after launch", {63'b0, v[28]}, 64'd1);
    check(v[26:16] == {rd, rg, phy}, "R2 field readback", {53'b0, v[26:16]}, {53'b0, rd, rg, phy});
    n = 0;
    if (intrude) begin
      repeat (40) @(negedge clk);
      busWrite(1'b0, mkCmd(~rd, ~phy, ~rg, ~d));
      peek(1'b0, v);
      check(v[26:16] == {rd, rg, phy}, "R8 fields kept on busy write", {53'b0, v[26:16]}, {53'b0, rd, rg, phy});
    end
    forever begin
      regSel = 1'b0;
      #1;
      if (!rdData[28]) break;
      @(negedge clk);
      n++;
    end
    if (!intrude)
      check(n == 128*CLK_DIV, "R7 frame duration", 64'(n), 64'(128*CLK_DIV));
    check(riseCnt == 64, "R7 MDC edge count", 64'(riseCnt), 64'd64);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R7 idle pins", {62'b0, mdc, mdioOe}, 64'd0);
    capOn = 0;
    if (!rd) begin
      check(capOe == 64'hFFFF_FFFF_FFFF_FFFF, intrude ? "R8 enable pattern" : "R3 enable pattern", capOe, 64'hFFFF_FFFF_FFFF_FFFF);
      check(capBits == exp, intrude ? "R8 frame unchanged" : "R3 write frame", capBits, exp);
      peek(1'b0, v);
      check(v[27] == 1'b0 && v[15:0] == d, "R3 write status", {32'b0, v}, {32'b0, 5'b0, 1'b0, rd, rg, phy, d});
    end else begin
      check(capOe == RD_OE_MASK, intrude ? "R8 enable pattern" : "R4 release point", capOe, RD_OE_MASK);
      check((capBits & RD_OE_MASK) == exp, intrude ? "R8 frame unchanged" : "R4 read frame", capBits & RD_OE_MASK, exp);
      peek(1'b0, v);
      check(v[27] == 1'b1 && v[15:0] == resp, "R5 read data and valid", {32'b0, v}, {32'b0, 5'b0, 1'b1, rd, rg, phy, resp});
      repeat (5) @(negedge clk);
      peek(1'b0, v);
      check(v[27] == 1'b1, "R6 valid held", {63'b0, v[27]}, 64'd1);
      @(negedge clk);
      busRead(1'b0, v);
      check(v[27] == 1'b1 && v[15:0] == resp, "R6 read returns valid data", {32'b0, v}, {32'b0, 5'b0, 1'b1, rd, rg, phy, resp});
      peek(1'b0, v2);
      check(v2[27] == 1'b0 && v2[15:0] == resp, "R6 valid cleared by read", {32'b0, v2}, {32'b0, 5'b0, 1'b0, rd, rg, phy, resp});
    end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      finished = 1;
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240607));
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; regSel = 1'b0; wrData = '0; mdioIn = 1'b1;
    riseCnt = 0; fallCnt = 0; capBits = '0; capOe = '0; respWord = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(1'b0, v);
    check(v == 32'h0, "R1 command reg after reset", {32'b0, v}, 64'd0);
    check(mdc == 1'b0, "R1 mdc low", {63'b0, mdc}, 64'd0);
    check(mdioOe == 1'b0, "R1 oe low", {63'b0, mdioOe}, 64'd0);
    peek(1'b1, v);
    check(v == 32'h0, "R1 phy addr reg after reset", {32'b0, v}, 64'd0);
    @(negedge clk);

    // R9 PHY-address register
    busWrite(1'b1, 32'hFFFF_FFE5);
    peek(1'b1, v);
    check(v == 32'h0000_0005, "R9 low bits only", {32'b0, v}, 64'h5);
    @(negedge clk);
    busWrite(1'b1, 32'h0000_001F);
    peek(1'b1, v);
    check(v == 32'h0000_001F, "R9 full address", {32'b0, v}, 64'h1F);
    @(negedge clk);

    // directed corners
    runTxn(1'b0, 5'd0,  5'd31, 16'hFFFF, 16'h0000, 1'b0);
    runTxn(1'b0, 5'd31, 5'd0,  16'h0000, 16'h0000, 1'b0);
    runTxn(1'b1, 5'd0,  5'd31, 16'h0000, 16'h8001, 1'b0);
    runTxn(1'b1, 5'd31, 5'd0,  16'h0000, 16'hFFFF, 1'b0);
    runTxn(1'b1, 5'd5,  5'd1,  16'h0000, 16'h0000, 1'b0);

    // R8 command written while busy
    runTxn(1'b0, 5'd9,  5'd17, 16'hA5C3, 16'h0000, 1'b1);
    runTxn(1'b1, 5'd22, 5'd3,  16'h0000, 16'h5A3C, 1'b1);

    // R10 reserved bits set: rejected
    busWrite(1'b0, 32'h4000_0000 | mkCmd(1'b0, 5'd1, 5'd2, 16'h1234));
    peek(1'b0, v);
    check(v[28] == 1'b0, "R10 no launch", {63'b0, v[28]}, 64'd0);
    check(v[26:16] == {1'b1, 5'd3, 5'd22}, "R10 fields kept", {53'b0, v[26:16]}, {53'b0, 1'b1, 5'd3, 5'd22});
    @(negedge clk);
    busWrite(1'b0, 32'h0800_0000 | mkCmd(1'b0, 5'd1, 5'd2, 16'h1234));
    peek(1'b0, v);
    check(v[28] == 1'b0, "R10 status bit set rejected", {63'b0, v[28]}, 64'd0);
    @(negedge clk);

    // random mix
    for (int i = 0; i < 12; i++) begin
      logic [31:0] r;
      r = $urandom;
      runTxn(r[0], r[5:1], r[10:6], r[26:11], 16'($urandom), 1'b0);
    end

    // R9 register unaffected by command traffic
    peek(1'b1, v);
    check(v == 32'h0000_001F, "R9 retained", {32'b0, v}, 64'h1F);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule